// File: doc/BRIEF.md
# AXI Burst Address Generator

This block produces the byte address of every beat of an AXI4 burst when only the first address is known. A load strobe captures the start address, the size code, the length and the burst type. Each advance strobe then moves the block to the address of the next beat. Three burst types are supported. A fixed burst repeats the start address. An incrementing burst steps by the transfer size. A wrapping burst cycles inside an aligned window. A last-beat flag marks the final beat. An illegal flag reports a request that breaks the burst rules: a bad wrapping length or alignment, an incrementing burst that crosses a 4 KB page, the reserved type code, or a size wider than the data bus.

The block sits beside the address and data channels of a slave or a memory controller. The channel logic pulses the load strobe when it accepts an address-channel request. It pulses the advance strobe on each accepted data beat. The address output then feeds the memory array or the byte-lane logic. Both strobes are plain one-cycle controls and there is no back-pressure. The outputs change only on a load or on an accepted advance, and they hold their value until one of these occurs. Everything is registered, so results appear one clock after the strobe.

Top module: `axi_burst_addr_gen`

## Requirements
- R1: A load strobe makes the address output equal the start address one cycle later and restarts the beat count. When load and advance are high together, load wins.
- R2: The burst type code is 00 fixed, 01 incrementing, 10 wrapping and 11 reserved. In a fixed burst each advance leaves the address unchanged.
- R3: In an incrementing burst with size code S, beat k (k ≥ 1) has the address (start with its low S bits cleared) + k·2^S. Only the first beat can be unaligned.
- R4: In a wrapping burst the window is 2^S·(length+1) bytes and is aligned to its own size. Each advance adds 2^S, and on passing the top of the window the address returns to the window's low edge.
- R5: The length input equals the beat count minus one (0 to 255). The last flag is high exactly when the number of advances since the load equals the length.
- R6: An advance while the last flag is high has no effect: the address and the flags hold.
- R7: A wrapping burst whose start address is not a multiple of 2^S, or whose length input is not 1, 3, 7 or 15, raises the illegal flag.
- R8: An incrementing burst whose bytes, from the aligned start to the end of its final beat, span more than one 4 KB page raises the illegal flag. A burst that ends exactly on the page's last byte stays legal.
- R9: The reserved type code 11 raises the illegal flag.
- R10: A size code greater than the bus width code (default 3, an 8-byte bus) raises the illegal flag.
- R11: The illegal flag is evaluated at load, appears one cycle later and holds until the next load. Fixed bursts with a legal size are never flagged.
- R12: After reset the address is 0, the last flag is 1 and the illegal flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture a new burst request |
| start_addr_i | input | ADDR_W | Start byte address of the burst |
| size_i | input | 3 | Size code S; bytes per beat = 2^S |
| len_i | input | 8 | Beat count minus one |
| burst_i | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| advance_i | input | 1 | Current beat accepted; step to the next one |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| illegal_o | output | 1 | The loaded request breaks a burst rule |

## Verification
The bench builds the block with a 16-bit address and the default 8-byte bus. With this setting a random start address often lands near a 4 KB page edge or near the top of the address space, where an incrementing burst can run past 0xFFFF. The default bus width keeps size codes 4 to 7 in range as inputs, so the illegal-size rule is exercised alongside the legal sizes 0 to 3. Length 255 together with 8-byte beats gives a 2 KB burst, which brings page crossings within reach from many start offsets.

// File: rtl/abag_pkg.sv
package abag_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;
endpackage

// File: rtl/abag_legal.sv
// Checks one burst request against the burst rules (combinational).
module abag_legal
  import abag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int BUS_LOG2  = 3,
  parameter int PAGE_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  burst_e            kind_i,
  output logic              bad_o
);
  localparam int         EXT_W    = ADDR_W + LEN_W + 9;
  localparam logic [2:0] SIZE_LIM = 3'(BUS_LOG2);
  localparam int         N_WRAP   = 4;

  logic [ADDR_W-1:0] lane_mask;
  logic [EXT_W-1:0]  span, end_byte;
  logic              size_bad, crosses, misaligned, wrap_len_ok;
  logic [N_WRAP-1:0] wrap_hit;

  // Wrap lengths 2, 4, 8 and 16 beats: the length input is 2^(i+1)-1.
  for (genvar i = 0; i < N_WRAP; i++) begin : g_wrap_len
    assign wrap_hit[i] = (len_i == LEN_W'((1 << (i + 1)) - 1));
  end
  assign wrap_len_ok = |wrap_hit;

  assign lane_mask  = (ADDR_W'(1) << size_i) - ADDR_W'(1);
  assign misaligned = |(start_i & lane_mask);
  assign size_bad   = size_i > SIZE_LIM;
  assign span       = (EXT_W'(len_i) + EXT_W'(1)) << size_i;
  assign end_byte   = EXT_W'(start_i & ~lane_mask) + span - EXT_W'(1);
  assign crosses    = (end_byte >> PAGE_LOG2) != (EXT_W'(start_i) >> PAGE_LOG2);

  always_comb begin
    unique case (kind_i)
      BT_FIXED: bad_o = size_bad;
      BT_INCR:  bad_o = size_bad | crosses;
      BT_WRAP:  bad_o = size_bad | misaligned | !wrap_len_ok;
      default:  bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/abag_step.sv
// Next-beat address for the registered burst parameters (combinational).
module abag_step
  import abag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  burst_e            kind_i,
  output logic [ADDR_W-1:0] next_o,
  output logic [ADDR_W-1:0] win_mask_o
);
  logic [ADDR_W-1:0] beat_bytes, lane_mask, incr_next, wrap_next;

  assign beat_bytes = ADDR_W'(1) << size_i;
  assign lane_mask  = beat_bytes - ADDR_W'(1);
  // Window of (len+1) beats; a power of two for every legal wrap length.
  assign win_mask_o = (ADDR_W'(len_i) << size_i) | lane_mask;
  assign incr_next  = (addr_i & ~lane_mask) + beat_bytes;
  assign wrap_next  = (addr_i & ~win_mask_o) | ((addr_i + beat_bytes) & win_mask_o);

  always_comb begin
    unique case (kind_i)
      BT_INCR: next_o = incr_next;
      BT_WRAP: next_o = wrap_next;
      default: next_o = addr_i;
    endcase
  end
endmodule

// File: rtl/abag_beat_cnt.sv
// Counts accepted beats and flags the final one.
module abag_beat_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             advance_i,
  input  logic [LEN_W-1:0] len_q_i,
  output logic             last_o,
  output logic             step_o
);
  logic [LEN_W-1:0] beat_q;

  assign last_o = (beat_q == len_q_i);
  assign step_o = advance_i && !load_i && !last_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_o) beat_q <= beat_q + LEN_W'(1);
  end

  // R5: the count can never run past the stored length
  assert_beat_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !load_i) |=> last_o);
endmodule

// File: rtl/axi_burst_addr_gen.sv
module axi_burst_addr_gen
  import abag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_LOG2  = 3,
  parameter int PAGE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        size_i,
  input  logic [7:0]        len_i,
  input  logic [1:0]        burst_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              illegal_o
);
  localparam int LEN_W = 8;

  logic [ADDR_W-1:0] addr_q, next_addr, win_mask;
  logic [2:0]        size_q;
  logic [LEN_W-1:0]  len_q;
  burst_e            kind_q;
  logic              bad_q, req_bad, step;

  abag_legal #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_LOG2(BUS_LOG2),
               .PAGE_LOG2(PAGE_LOG2)) legal_i (
    .start_i (start_addr_i),
    .size_i  (size_i),
    .len_i   (len_i),
    .kind_i  (burst_e'(burst_i)),
    .bad_o   (req_bad)
  );

  abag_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) step_i (
    .addr_i     (addr_q),
    .size_i     (size_q),
    .len_i      (len_q),
    .kind_i     (kind_q),
    .next_o     (next_addr),
    .win_mask_o (win_mask)
  );

  abag_beat_cnt #(.LEN_W(LEN_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .advance_i (advance_i),
    .len_q_i   (len_q),
    .last_o    (last_o),
    .step_o    (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= '0;
      len_q  <= '0;
      kind_q <= BT_FIXED;
      bad_q  <= 1'b0;
    end else if (load_i) begin
      addr_q <= start_addr_i;
      size_q <= size_i;
      len_q  <= len_i;
      kind_q <= burst_e'(burst_i);
      bad_q  <= req_bad;
    end else if (step) begin
      addr_q <= next_addr;
    end
  end

  assign addr_o    = addr_q;
  assign illegal_o = bad_q;

  // R1: load places the start address and restarts the count
  assert_load_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(start_addr_i)) && (last_o == ($past(len_i) == '0)));
  // R2: fixed bursts keep their address
  assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && kind_q == BT_FIXED) |=> $stable(addr_o));
  // R3: after a step in an incrementing burst the address is size-aligned
  assert_incr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i && !last_o && kind_q == BT_INCR)
      |=> ((addr_o & ((ADDR_W'(1) << size_q) - ADDR_W'(1))) == '0));
  // R4: a wrapping step never leaves its window
  assert_wrap_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i && kind_q == BT_WRAP)
      |=> ((addr_o & ~win_mask) == ($past(addr_o) & ~win_mask)));
  // R6: an advance on the last beat changes nothing
  assert_last_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i && last_o) |=> ($stable(addr_o) && last_o && $stable(illegal_o)));
  // R9: the reserved type code is always flagged
  assert_rsvd_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && burst_i == 2'b11) |=> illegal_o);
  // R11: the flag only moves on a load
  assert_flag_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(illegal_o));
endmodule

// File: tb/axi_burst_addr_gen_tb.sv
`timescale 1ns/1ps
module axi_burst_addr_gen_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [2:0]    size_i = '0;
  logic [7:0]    len_i = '0;
  logic [1:0]    burst_i = '0;
  logic          advance_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          last_o, illegal_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  axi_burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .size_i(size_i), .len_i(len_i), .burst_i(burst_i), .advance_i(advance_i),
    .addr_o(addr_o), .last_o(last_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint exp_addr(longint s, int sz, int ln, int bt, int k);
    longint b = longint'(1) << sz;
    longint r;
    longint win, base;
    case (bt)
      1: r = (k == 0) ? s : ((s / b) * b) + longint'(k) * b;
      2: begin
        win  = b * (ln + 1);
        base = (s / win) * win;
        r    = base + ((s - base) + longint'(k) * b) % win;
      end
      default: r = s;
    endcase
    return r & ((longint'(1) << AW) - 1);
  endfunction

  function automatic bit exp_bad(longint s, int sz, int ln, int bt);
    longint b = longint'(1) << sz;
    bit bad = (sz > 3);
    if (bt == 3) bad = 1'b1;
    if (bt == 2 && ((s % b) != 0 || !(ln == 1 || ln == 3 || ln == 7 || ln == 15))) bad = 1'b1;
    if (bt == 1 && ((((s / b) * b + (ln + 1) * b - 1) >> 12) != (s >> 12))) bad = 1'b1;
    return bad;
  endfunction

  // Runs a whole burst, checking every beat, idle gaps and the extra advance at the end.
  task automatic run_burst(input longint s, input int sz, input int ln, input int bt,
                           input bit gaps);
    bit bad = exp_bad(s, sz, ln, bt);
    bit chk_addr = !(bt == 3 || sz > 3 || (bt == 2 && bad));
    @(negedge clk);
    load_i = 1'b1; start_addr_i = AW'(s); size_i = 3'(sz); len_i = 8'(ln);
    burst_i = 2'(bt); advance_i = 1'b0;
    @(negedge clk);
    load_i = 1'b0;
    chk("R1 start address", addr_o, exp_addr(s, sz, ln, bt, 0));
    chk("R5 last after load", last_o, ln == 0);
    chk(bt == 3 ? "R9 reserved" : (sz > 3 ? "R10 size" : (bt == 2 ? "R7 wrap rules" :
        (bt == 1 ? "R8 page crossing" : "R11 fixed legal"))), illegal_o, bad);
    for (int k = 1; k <= ln; k++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        if (chk_addr) chk("R6 idle hold", addr_o, exp_addr(s, sz, ln, bt, k - 1));
      end
      advance_i = 1'b1;
      @(negedge clk);
      advance_i = 1'b0;
      if (chk_addr)
        chk(bt == 0 ? "R2 fixed beat" : (bt == 1 ? "R3 incr beat" : "R4 wrap beat"),
            addr_o, exp_addr(s, sz, ln, bt, k));
      chk("R5 last flag", last_o, k == ln);
      chk("R11 flag held", illegal_o, bad);
    end
    advance_i = 1'b1;
    @(negedge clk);
    advance_i = 1'b0;
    if (chk_addr) chk("R6 advance at last", addr_o, exp_addr(s, sz, ln, bt, ln));
    chk("R6 last stays", last_o, 1);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R12 reset addr", addr_o, 0);
    chk("R12 reset last", last_o, 1);
    chk("R12 reset illegal", illegal_o, 0);
    rst_n = 1'b1;

    // Directed corners
    run_burst(64'h0038, 2, 3, 2, 1'b0);   // R4: 38,3C,30,34
    chk("R4 wrap returned", addr_o, 64'h0034);
    run_burst(64'h1003, 2, 4, 1, 1'b0);   // R3: unaligned first beat
    run_burst(64'h0200, 3, 5, 0, 1'b1);   // R2 fixed
    run_burst(64'h0FF8, 3, 1, 1, 1'b0);   // R8 crosses
    run_burst(64'h0FF0, 3, 1, 1, 1'b0);   // R8 ends on last byte, legal
    run_burst(64'h0032, 2, 3, 2, 1'b0);   // R7 misaligned wrap
    run_burst(64'h0040, 2, 5, 2, 1'b0);   // R7 bad wrap length
    run_burst(64'h0070, 0, 15, 2, 1'b0);  // R4 byte wrap of 16
    run_burst(64'h0100, 1, 2, 3, 1'b0);   // R9 reserved
    run_burst(64'h0100, 4, 1, 0, 1'b0);   // R10 oversize
    run_burst(64'h0000, 0, 0, 1, 1'b0);   // single beat
    run_burst(64'h0800, 3, 255, 1, 1'b0); // 2 KB, legal
    run_burst(64'hFFF8, 3, 1, 1, 1'b0);   // past address top, R8

    // R1: load beats a simultaneous advance
    @(negedge clk);
    load_i = 1'b1; start_addr_i = 16'h4000; size_i = 3'd2; len_i = 8'd7; burst_i = 2'b01;
    @(negedge clk);
    load_i = 1'b0; advance_i = 1'b1;
    @(negedge clk);
    chk("R3 mid burst", addr_o, 16'h4004);
    load_i = 1'b1; start_addr_i = 16'h5550; len_i = 8'd3;
    @(negedge clk);
    load_i = 1'b0; advance_i = 1'b0;
    chk("R1 load priority addr", addr_o, 16'h5550);
    chk("R1 load priority last", last_o, 0);

    // Constrained random bursts
    for (int n = 0; n < 400; n++) begin
      longint s = longint'($urandom % 65536);
      int sel = int'($urandom % 8);
      int bt = (sel < 3) ? 1 : (sel < 6) ? 2 : (sel < 7) ? 0 : 3;
      int sz = ($urandom % 10 == 0) ? int'(4 + $urandom % 4) : int'($urandom % 4);
      int ln;
      if ($urandom % 3 == 0) s = (s & 64'hF000) | (64'h0F00 + longint'($urandom % 256));
      if (bt == 2 && ($urandom % 5 != 0)) begin
        ln = (2 << ($urandom % 4)) - 1;
        s = (s >> sz) << sz;
      end else begin
        ln = ($urandom % 16 == 0) ? 255 : int'($urandom % 32);
      end
      run_burst(s, sz, ln, bt, 1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule